// File: doc/BRIEF.md
# Parallel and Byte Result Read Port

This block presents a 12-bit conversion result to a host bus. When a new result arrives with its strobe, the word is captured in a holding register. A host then reads it under active-low chip select and read. A format input picks one of two ways of reading. In word mode the whole 12-bit value is driven at once. In byte mode the host makes two 8-bit reads.

In byte mode the topmost data line is no longer an output. The host uses it as a high-byte select input, which appears here as a separate input port. Lines 11 to 8 are then left undriven, because their pins are handed to other functions. The data lines come out as a value vector together with a per-line output-enable vector. A pad ring can combine them into tri-state pins.

The block also produces a one-cycle interrupt clear request. It is raised on the first read that starts after a new result has arrived.

Top module: `byte_read_port`

## Requirements
- R1: While reset is asserted and directly after it, every output enable is low and the clear request is low. The held word is zero, so a read before the first strobe returns zero.
- R2: With the format input high (word mode) and both chip select and read low, all 12 enables are high. Line n carries held bit n, with the MSB on line 11 and the LSB on line 0.
- R3: Whenever chip select or read is high, all 12 output enables are low.
- R4: With the format input low (byte mode), the high-byte select low, and a read active, lines 7 to 0 carry held bits 7 to 0 and their enables are high.
- R5: In byte mode with the high-byte select high and a read active, lines 3 to 0 carry held bits 11 to 8, lines 7 to 4 carry zero, and enables 7 to 0 are high.
- R6: In byte mode, the enables of lines 11 to 8 stay low at all times.
- R7: The held word changes only on a clock edge where the new-result strobe is high. Changes on the result input at any other time have no effect on the data that is read.
- R8: The clear request is high during the cycle in which a read starts, meaning chip select and read are both low and were not both low at the previous edge, but only if a strobe has loaded a result since the last such pulse. The request is raised in either format, whichever byte is selected. Later reads of the same result give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_word | input | 12 | Conversion result to capture |
| res_strobe | input | 1 | New-result strobe; loads res_word |
| fmt_word | input | 1 | 1 = 12-bit word reads, 0 = byte reads |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| hbe | input | 1 | High-byte select, used in byte mode only |
| data_out | output | 12 | Data line values |
| data_oe | output | 12 | Per-line output enable |
| irq_clr | output | 1 | One-cycle interrupt clear request |

## Verification
Suppose the holding register loads when it should not, or misses a strobe. The next read then shows the stale or corrupted bits on the data lines at once, within the same cycle as that read. Suppose the pending flag or the previous-read register is wrong. The clear request then either goes missing on the first read after a strobe or appears again on a repeated read, and this shows during the cycle in which that read starts. Steering faults show up as misplaced or non-zero nibbles, or as stray enables, on the very read that selects the faulty format and byte.

// File: rtl/brp_pkg.sv
package brp_pkg;
  localparam int unsigned WORD_W = 12;
  localparam int unsigned LANE_W = 8;
  typedef enum logic {
    FMT_BYTE = 1'b0,
    FMT_WORD = 1'b1
  } fmt_e;
endpackage

// File: rtl/brp_hold_reg.sv
module brp_hold_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (load_en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R7
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> q == $past(d));
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(q));
endmodule

// File: rtl/brp_lane_steer.sv
module brp_lane_steer #(
  parameter int unsigned W  = 12,
  parameter int unsigned LW = 8
) (
  input  logic         word_mode,
  input  logic         active,
  input  logic         hi_sel,
  input  logic [W-1:0] held,
  output logic [W-1:0] lane_d,
  output logic [W-1:0] lane_oe
);
  localparam int unsigned HI_W = W - LW;

  for (genvar g = 0; g < W; g++) begin : g_lane
    if (g < LW) begin : g_low
      logic hi_bit;
      if (g < HI_W) begin : g_src
        assign hi_bit = held[LW+g];
      end else begin : g_zero
        assign hi_bit = 1'b0;
      end
      assign lane_d[g]  = (!word_mode && hi_sel) ? hi_bit : held[g];
      assign lane_oe[g] = active;
    end else begin : g_top
      assign lane_d[g]  = word_mode ? held[g] : 1'b0;
      assign lane_oe[g] = active && word_mode;
    end
  end
endmodule

// File: rtl/brp_clear_gen.sv
module brp_clear_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic new_res,
  input  logic active,
  output logic clr_req
);
  logic act_prev, act_prev_next;
  logic pend, pend_next;
  logic start;

  assign start   = active && !act_prev;
  assign clr_req = start && pend;

  always_comb begin
    act_prev_next = active;
    pend_next     = pend;
    if (clr_req) pend_next = 1'b0;
    if (new_res) pend_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev <= 1'b0;
      pend     <= 1'b0;
    end else begin
      act_prev <= act_prev_next;
      pend     <= pend_next;
    end
  end

  // R8
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !clr_req);
  // R8
  clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |-> active);
endmodule

// File: rtl/byte_read_port.sv
module byte_read_port
  import brp_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned LW = LANE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] res_word,
  input  logic         res_strobe,
  input  logic         fmt_word,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         hbe,
  output logic [W-1:0] data_out,
  output logic [W-1:0] data_oe,
  output logic         irq_clr
);
  localparam int unsigned HI_W = W - LW;

  fmt_e         fmt;
  logic         rd_act;
  logic [W-1:0] held;

  assign fmt    = fmt_e'(fmt_word);
  assign rd_act = !cs_n && !rd_n;

  brp_hold_reg #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_en(res_strobe), .d(res_word), .q(held));

  brp_lane_steer #(.W(W), .LW(LW)) u_steer (
    .word_mode(fmt == FMT_WORD), .active(rd_act), .hi_sel(hbe),
    .held(held), .lane_d(data_out), .lane_oe(data_oe));

  brp_clear_gen u_clr (
    .clk(clk), .rst_n(rst_n), .new_res(res_strobe), .active(rd_act),
    .clr_req(irq_clr));

  // R3
  idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> data_oe == '0);
  // R6
  byte_top_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_BYTE) |-> data_oe[W-1:LW] == '0);
  // R5
  hi_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_BYTE && rd_act && hbe) |-> data_out[LW-1:HI_W] == '0);
  // R2
  word_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_WORD && rd_act) |-> data_oe == '1);
endmodule

// File: tb/byte_read_port_tb.sv
module byte_read_port_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] res_word = '0;
  logic        res_strobe = 1'b0;
  logic        fmt_word = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        hbe = 1'b0;
  logic [11:0] data_out, data_oe;
  logic        irq_clr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  byte_read_port dut_i (
    .clk(clk), .rst_n(rst_n), .res_word(res_word), .res_strobe(res_strobe),
    .fmt_word(fmt_word), .cs_n(cs_n), .rd_n(rd_n), .hbe(hbe),
    .data_out(data_out), .data_oe(data_oe), .irq_clr(irq_clr));

  function automatic logic [11:0] exp_oe(input bit wmode, input bit act);
    if (!act) return 12'h000;
    return wmode ? 12'hFFF : 12'h0FF;
  endfunction

  function automatic logic [11:0] exp_data(input logic [11:0] w, input bit wmode, input bit hi);
    if (wmode) return w;
    return hi ? {4'h0, 4'h0, w[11:8]} : {4'h0, w[7:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [11:0] w);
    @(negedge clk);
    res_word = w; res_strobe = 1'b1;
    @(negedge clk);
    res_strobe = 1'b0;
  endtask

  // one read; caller gives expected word and clear pulse
  task automatic do_read(input bit wmode, input bit hi, input logic [11:0] w,
                         input bit exp_clr, input string req);
    fmt_word = wmode; hbe = hi;
    cs_n = 1'b0; rd_n = 1'b0;
    #2;
    chk(req, data_oe, exp_oe(wmode, 1'b1));
    chk(req, data_out & exp_oe(wmode, 1'b1), exp_data(w, wmode, hi));
    chk("R8", irq_clr, exp_clr);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    #2;
    chk("R3", data_oe, 12'h000);
    if (!wmode) chk("R6", data_oe[11:8], 4'h0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_P * 2 + 2);
    chk("R1", data_oe, 12'h000);
    chk("R1", irq_clr, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(1'b1, 1'b0, 12'h000, 1'b0, "R1");

    // directed: word mode pattern, byte low, byte high, cs only, rd only
    load(12'hA5C);
    do_read(1'b1, 1'b0, 12'hA5C, 1'b1, "R2");
    do_read(1'b0, 1'b0, 12'hA5C, 1'b0, "R4");
    do_read(1'b0, 1'b1, 12'hA5C, 1'b0, "R5");
    load(12'hFFF);
    do_read(1'b0, 1'b1, 12'hFFF, 1'b1, "R5");
    fmt_word = 1'b1; cs_n = 1'b0; rd_n = 1'b1; #2;
    chk("R3", data_oe, 12'h000);
    cs_n = 1'b1; rd_n = 1'b0; #2;
    chk("R3", data_oe, 12'h000);
    rd_n = 1'b1;
    // byte mode, no read: top lanes off
    fmt_word = 1'b0; #2;
    chk("R6", data_oe, 12'h000);
    @(negedge clk);

    // R7: input changes without strobe are ignored
    res_word = 12'h123;
    @(negedge clk); @(negedge clk);
    do_read(1'b1, 1'b0, 12'hFFF, 1'b0, "R7");

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [11:0] w;
      bit m, h;
      w = 12'($urandom);
      m = 1'($urandom);
      h = 1'($urandom);
      load(w);
      res_word = 12'($urandom);
      do_read(m, h, w, 1'b1, m ? "R2" : (h ? "R5" : "R4"));
      do_read(1'b0, ~h, w, 1'b0, h ? "R4" : "R5");
      if (i % 5 == 0) do_read(1'b1, 1'b0, w, 1'b0, "R7");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule